// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Pair

This block produces the two comparison pulses a phase-frequency detector needs in a frequency synthesizer. The feedback path divides a VCO-rate clock by a programmable ratio M. It does this with a synchronous divide-by-16/17 prescaler, a 4-bit swallow counter and a 10-bit main counter, so that M = 16*P + A. The reference path divides a separate reference clock by a programmable ratio R with a plain down counter. Each path emits a pulse one clock of its own domain wide, once per division period.

Two full ratio banks are provided, (M1, R1) and (M2, R2). A single bank-select input chooses between them. The select is synchronised separately into each clock domain. A counter takes a new ratio or a new bank only when it reloads at its terminal count, so an output period is never cut short or stretched by a change. A 14-bit M below 256 is treated as 256, and an 11-bit R below 2 is treated as 2. This keeps the swallow count within the main count and keeps the reference divider meaningful.

Top module: `syndiv_pair`

## Requirements
- R1: With bank 1 selected and held, the spacing between successive rising edges of `m_pulse` is exactly `m_bank1` VCO clock cycles, for any value from 256 to 16383. The value is split as main count = bits [13:4] and swallow count = bits [3:0].
- R2: With the bank held, the spacing between successive `r_pulse` pulses is exactly the selected R value in reference clock cycles, for any value from 2 to 2047.
- R3: `bank_sel` = 1 selects `m_bank1`/`r_bank1` and `bank_sel` = 0 selects `m_bank2`/`r_bank2`, for both dividers.
- R4: An M value below 256 divides by 256. An R value below 2 divides by 2.
- R5: Each `m_pulse` is high for exactly one VCO clock cycle, and each `r_pulse` is high for exactly one reference clock cycle.
- R6: A change of bank or of ratio value is applied only when a divider reloads at its terminal count. The period in progress completes at its old length, and the period following the change has the new length at the latest.
- R7: While `rst_n` is low, both `m_pulse` and `r_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO-rate clock divided by M |
| ref_clk | input | 1 | Reference clock divided by R |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bank_sel | input | 1 | 1 selects bank 1, 0 selects bank 2 |
| m_bank1 | input | 14 | Feedback ratio, bank 1 |
| m_bank2 | input | 14 | Feedback ratio, bank 2 |
| r_bank1 | input | 11 | Reference ratio, bank 1 |
| r_bank2 | input | 11 | Reference ratio, bank 2 |
| m_pulse | output | 1 | One VCO cycle pulse per M period |
| r_pulse | output | 1 | One reference cycle pulse per R period |

## Verification
Two events can fall in the same VCO cycle: a bank switch arriving through the select synchroniser, and the terminal-count reload of the feedback divider. The bench toggles the select one, two and three cycles before a known pulse. It judges that the period ending at that pulse keeps its old length. The period that follows must have either the old or the new length, and the period after that must have the new length. A mid-period toggle and a mid-period change of the reference value are also applied, and the bench checks that they take effect only at the next reload.

// File: rtl/syndiv_pkg.sv
package syndiv_pkg;
  // feedback ratio width and its swallow part
  localparam int FB_W       = 14;
  localparam int SWALLOW_W  = 4;
  // reference ratio width
  localparam int RF_W       = 11;
  // smallest honoured ratios
  localparam int FB_FLOOR   = 256;
  localparam int RF_FLOOR   = 2;
  // synchroniser depth for reset release and bank select
  localparam int SYNC_DEPTH = 2;
  // customary start-up ratios for a system controller
  localparam int FB1_START  = 10519;
  localparam int FB2_START  = 4269;
  localparam int RF_START   = 492;

  typedef enum logic {BANK_TWO = 1'b0, BANK_ONE = 1'b1} bank_e;
endpackage

// File: rtl/syndiv_sync.sv
module syndiv_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stage_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q[i] <= 1'b0;
        else         stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q[i] <= 1'b0;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/syndiv_prescaler.sv
module syndiv_prescaler #(
  parameter int BASE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic extend,   // 1: divide by 2**BASE_W + 1, 0: by 2**BASE_W
  output logic tc
);
  localparam int CNT_W = BASE_W + 1;
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'((2 ** BASE_W) - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(2 ** BASE_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tc    = (cnt_q == (extend ? LAST_LONG : LAST_SHORT));
    cnt_d = tc ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // modulus only changes at a wrap, so a short cycle never sees the long count
  p_short_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !extend |-> (cnt_q <= LAST_SHORT));
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_LONG);
endmodule

// File: rtl/syndiv_mdiv.sv
module syndiv_mdiv #(
  parameter int FB_W      = 14,
  parameter int SWALLOW_W = 4,
  parameter int FB_FLOOR  = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] ratio,
  output logic            pulse
);
  localparam int MAIN_W = FB_W - SWALLOW_W;
  localparam logic [FB_W-1:0]   FLOOR_V  = FB_W'(FB_FLOOR);
  localparam logic [MAIN_W-1:0] MAIN_ONE = MAIN_W'(1);

  logic [FB_W-1:0]      eff;
  logic [SWALLOW_W-1:0] swl_q, swl_d;
  logic [MAIN_W-1:0]    main_q, main_d;
  logic                 pre_tc, wrap, pulse_q;

  syndiv_prescaler #(.BASE_W(SWALLOW_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .extend (swl_q != '0),
    .tc     (pre_tc)
  );

  always_comb begin
    eff    = (ratio < FLOOR_V) ? FLOOR_V : ratio;
    wrap   = pre_tc && (main_q == MAIN_ONE);
    swl_d  = swl_q;
    main_d = main_q;
    if (pre_tc) begin
      if (wrap) begin
        swl_d  = eff[SWALLOW_W-1:0];
        main_d = eff[FB_W-1:SWALLOW_W];
      end else begin
        main_d = main_q - 1'b1;
        if (swl_q != '0) swl_d = swl_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swl_q   <= '0;
      main_q  <= MAIN_ONE;
      pulse_q <= 1'b0;
    end else begin
      swl_q   <= swl_d;
      main_q  <= main_d;
      pulse_q <= wrap;
    end
  end

  assign pulse = pulse_q;

  p_main_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    main_q != '0);
  p_swallow_le_main_r1: assert property (@(posedge clk) disable iff (!rst_n)
    MAIN_W'(swl_q) <= main_q);
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_load_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ({main_q, swl_q} >= FLOOR_V));
endmodule

// File: rtl/syndiv_rdiv.sv
module syndiv_rdiv #(
  parameter int RF_W     = 11,
  parameter int RF_FLOOR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RF_W-1:0] ratio,
  output logic            pulse
);
  localparam logic [RF_W-1:0] FLOOR_V = RF_W'(RF_FLOOR);
  localparam logic [RF_W-1:0] ONE_V   = RF_W'(1);

  logic [RF_W-1:0] eff, cnt_q, cnt_d;
  logic            wrap, pulse_q;

  always_comb begin
    eff   = (ratio < FLOOR_V) ? FLOOR_V : ratio;
    wrap  = (cnt_q == ONE_V);
    cnt_d = wrap ? eff : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= ONE_V;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= wrap;
    end
  end

  assign pulse = pulse_q;

  p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_load_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q >= FLOOR_V));
endmodule

// File: rtl/syndiv_pair.sv
module syndiv_pair
  import syndiv_pkg::*;
#(
  parameter int M_W   = FB_W,
  parameter int SW_W  = SWALLOW_W,
  parameter int R_W   = RF_W,
  parameter int M_MIN = FB_FLOOR,
  parameter int R_MIN = RF_FLOOR,
  parameter int SYNC  = SYNC_DEPTH
) (
  input  logic           vco_clk,
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic           bank_sel,
  input  logic [M_W-1:0] m_bank1,
  input  logic [M_W-1:0] m_bank2,
  input  logic [R_W-1:0] r_bank1,
  input  logic [R_W-1:0] r_bank2,
  output logic           m_pulse,
  output logic           r_pulse
);
  logic  vco_rst_n, ref_rst_n;
  logic  vco_sel_raw, ref_sel_raw;
  bank_e vco_bank, ref_bank;
  logic [M_W-1:0] m_ratio;
  logic [R_W-1:0] r_ratio;

  // reset release and bank select, one chain per clock domain
  syndiv_sync #(.DEPTH(SYNC)) u_vco_rst (
    .clk(vco_clk), .arst_n(rst_n), .d(1'b1), .q(vco_rst_n));
  syndiv_sync #(.DEPTH(SYNC)) u_ref_rst (
    .clk(ref_clk), .arst_n(rst_n), .d(1'b1), .q(ref_rst_n));
  syndiv_sync #(.DEPTH(SYNC)) u_vco_sel (
    .clk(vco_clk), .arst_n(rst_n), .d(bank_sel), .q(vco_sel_raw));
  syndiv_sync #(.DEPTH(SYNC)) u_ref_sel (
    .clk(ref_clk), .arst_n(rst_n), .d(bank_sel), .q(ref_sel_raw));

  always_comb begin
    vco_bank = bank_e'(vco_sel_raw);
    ref_bank = bank_e'(ref_sel_raw);
    m_ratio  = (vco_bank == BANK_ONE) ? m_bank1 : m_bank2;
    r_ratio  = (ref_bank == BANK_ONE) ? r_bank1 : r_bank2;
  end

  syndiv_mdiv #(.FB_W(M_W), .SWALLOW_W(SW_W), .FB_FLOOR(M_MIN)) u_mdiv (
    .clk   (vco_clk),
    .rst_n (vco_rst_n),
    .ratio (m_ratio),
    .pulse (m_pulse)
  );

  syndiv_rdiv #(.RF_W(R_W), .RF_FLOOR(R_MIN)) u_rdiv (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .ratio (r_ratio),
    .pulse (r_pulse)
  );

  // pulses stay low until the domain has left reset
  p_quiet_reset_m_r7: assert property (@(posedge vco_clk)
    !vco_rst_n |=> !m_pulse);
  p_quiet_reset_r_r7: assert property (@(posedge ref_clk)
    !ref_rst_n |=> !r_pulse);
endmodule

// File: tb/tb_syndiv_pair.sv
module tb_syndiv_pair;
  logic        vco_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n;
  logic        bank_sel;
  logic [13:0] m_bank1, m_bank2;
  logic [10:0] r_bank1, r_bank2;
  logic        m_pulse, r_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 vco_clk = ~vco_clk;   // 50 MHz
  always #13 ref_clk = ~ref_clk;   // unrelated reference

  syndiv_pair dut (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .m_bank1(m_bank1), .m_bank2(m_bank2), .r_bank1(r_bank1), .r_bank2(r_bank2),
    .m_pulse(m_pulse), .r_pulse(r_pulse));

  // columns: sel, m1, m2, r1, r2, expected M spacing, expected R spacing
  localparam int NVEC = 8;
  localparam int VEC [NVEC][7] = '{
    '{1,   300, 4269,    5, 492,   300,    5},
    '{0,   300,  257,    5,   7,   257,    7},
    '{1,   511,  257, 2047,   7,   511, 2047},
    '{0,   511,  100, 2047,   1,   256,    2},
    '{1, 16383,  100,    2,   1, 16383,    2},
    '{0, 16383, 4096,    2,   3,  4096,    3},
    '{0, 10519, 4269,  492, 492,  4269,  492},
    '{1, 10519,    0,  492,   0, 10519,  492}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic m_sync;
    @(negedge vco_clk);
    while (!m_pulse) @(negedge vco_clk);
  endtask

  // counts VCO cycles to the next pulse; toggles the bank at count flip_at
  task automatic m_next(output int n, input int flip_at);
    n = 0;
    do begin
      @(negedge vco_clk);
      n++;
      if (n == flip_at) bank_sel = ~bank_sel;
    end while (!m_pulse && n < 40000);
  endtask

  task automatic r_sync;
    @(negedge ref_clk);
    while (!r_pulse) @(negedge ref_clk);
  endtask

  // counts reference cycles to the next pulse; rewrites r_bank1 at flip_at
  task automatic r_next(output int n, input int flip_at, input int new_r);
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
      if (n == flip_at) r_bank1 = 11'(new_r);
    end while (!r_pulse && n < 40000);
  endtask

  initial begin
    repeat (190000) @(posedge vco_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, n2, n3, cur, oth;
    rst_n = 1'b0; bank_sel = 1'b1;
    m_bank1 = 14'd300; m_bank2 = 14'd4269; r_bank1 = 11'd5; r_bank2 = 11'd492;

    // R7: quiet while held in reset
    repeat (6) @(negedge vco_clk);
    check("R7 m_pulse in reset", int'(m_pulse), 0);
    check("R7 r_pulse in reset", int'(r_pulse), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge vco_clk);
      bank_sel = VEC[i][0][0];
      m_bank1 = 14'(VEC[i][1]); m_bank2 = 14'(VEC[i][2]);
      r_bank1 = 11'(VEC[i][3]); r_bank2 = 11'(VEC[i][4]);
      m_sync; m_next(n, -1); m_next(n, -1);
      check($sformatf("R1/R3/R4 M spacing vector %0d", i), n, VEC[i][5]);
      r_sync; r_next(n, -1, 0); r_next(n, -1, 0);
      check($sformatf("R2/R3/R4 R spacing vector %0d", i), n, VEC[i][6]);
    end

    // R5: single-cycle pulses
    m_sync; @(negedge vco_clk);
    check("R5 m_pulse width", int'(m_pulse), 0);
    r_sync; @(negedge ref_clk);
    check("R5 r_pulse width", int'(r_pulse), 0);

    // R6: mid-period bank switch
    @(negedge vco_clk);
    bank_sel = 1'b1; m_bank1 = 14'd400; m_bank2 = 14'd600;
    m_sync; m_next(n, -1); m_next(n, -1);
    m_next(n, 50);
    check("R6 period holding bank switch", n, 400);
    m_next(n, -1);
    check("R6 period after bank switch", n, 600);

    // R6: switch landing next to the reload
    cur = 600; oth = 400;
    for (int k = 1; k <= 3; k++) begin
      m_next(n, cur - k);
      check($sformatf("R6 near-reload k=%0d current", k), n, cur);
      m_next(n2, -1);
      check($sformatf("R6 near-reload k=%0d following", k),
            (n2 == cur || n2 == oth) ? 1 : 0, 1);
      m_next(n3, -1);
      check($sformatf("R6 near-reload k=%0d settled", k), n3, oth);
      n = cur; cur = oth; oth = n;
    end

    // R6: mid-period change of the reference value (bank 1 now selected)
    r_bank1 = 11'd20;
    r_sync; r_next(n, -1, 0); r_next(n, -1, 0);
    r_next(n, 5, 33);
    check("R6 R period holding value change", n, 20);
    r_next(n, -1, 0);
    check("R6 R period after value change", n, 33);

    // R7: reset asserted mid-run
    @(negedge vco_clk);
    rst_n = 1'b0;
    repeat (3) @(negedge vco_clk);
    check("R7 m_pulse in mid-run reset", int'(m_pulse), 0);
    check("R7 r_pulse in mid-run reset", int'(r_pulse), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule